// File: doc/BRIEF.md
# Residue Register with Windowed Compare

This block holds the 40-bit residue of a shift-register checksum engine. Its companion is a 32-bit compare value. An external stepping datapath, which is outside this block, writes a new residue through a per-cycle update port and reads the current value from a parallel output. Software reaches everything through a small byte-addressed register bus. The residue appears as five byte registers, the compare value as four, and one control register sits beside them.

A single ordering bit does two jobs. It sets which residue byte each of the five residue addresses reaches. It also selects which 32 bits of the residue take part in the comparison: the upper window (bits 39:8) or the lower window (bits 31:0). When the datapath pulses its done strobe, the block registers whether the selected window equals the compare value. It holds that match result until the next strobe. A self-clearing preset bit loads all ones into the residue and clears the match result.

Top module: `residue_window_cmp`

## Requirements
- R1: After reset, the residue, the compare value, the ordering bit, the preset bit and the match flag are all zero.
- R2: Address map: residue registers at addresses 0 to 4, compare registers at 5 to 8, control register at 9. With ordering bit (control bit 0) clear, residue address i reads and writes residue bits 8i+7:8i. With it set, address i reaches bits 8(4-i)+7:8(4-i), so address 0 holds bits 39:32.
- R3: Writing 1 to control bit 1 (preset) sets the residue to all ones at the following clock edge. The preset bit reads 1 for exactly one cycle after the write and then reads 0.
- R4: A pending preset wins over an update or a residue bus write in the same cycle. It also clears the match flag.
- R5: When upd_valid is high, the residue takes upd_value at the next edge. The update wins over a residue bus write in the same cycle.
- R6: Compare address 5+k reads and writes compare-value bits 8k+7:8k, for k from 0 to 3.
- R7: With the ordering bit clear, op_done registers match = (residue[39:8] == compare[31:0]).
- R8: With the ordering bit set, op_done registers match = (residue[31:0] == compare[31:0]).
- R9: The match flag, also readable at control bit 2, holds its value until the next op_done or preset. Writes to control bit 2 are ignored.
- R10: Reads of addresses 10 to 15 return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| upd_valid | input | 1 | Residue update from the stepping datapath |
| upd_value | input | 40 | New residue value |
| op_done | input | 1 | Operation-complete strobe; samples the compare |
| residue_out | output | 40 | Current residue |
| match_flag | output | 1 | Registered compare result |

## Verification
The compare is exercised in both orderings with three kinds of pattern:
- A residue whose upper 32 bits equal the compare value, and the same bytes shifted so that its lower 32 bits equal it. Swapping the ordering bit between these two tells the upper window apart from the lower one.
- Residues that differ from the compare value only in the excluded byte. These must still match, which shows the window edges are exact.
- A residue that differs only in its top bit. This must fail in the upper window.

Each pattern is also read back through the byte registers and from the parallel output, so that a read mapping and a write mapping that are wrong in the same way cannot hide each other.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  localparam int BYTE_W     = 8;
  localparam int ORDER_BIT  = 0;
  localparam int PRESET_BIT = 1;
  localparam int MATCH_BIT  = 2;
endpackage

// File: rtl/rwc_residue.sv
module rwc_residue
  import rwc_pkg::*;
#(
  parameter int RES_W = 40,
  localparam int NBYTE = RES_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic              preset,
  input  logic              upd_valid,
  input  logic [RES_W-1:0]  upd_value,
  input  logic [NBYTE-1:0]  byte_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [RES_W-1:0]  res_q
);
  logic [RES_W-1:0] res_n;
  logic             res_en;

  always_comb begin
    res_n  = res_q;
    res_en = preset | upd_valid | (|byte_we);
    if (preset) begin
      res_n = '1;
    end else if (upd_valid) begin
      res_n = upd_value;
    end else begin
      for (int p = 0; p < NBYTE; p++) begin
        if (byte_we[p]) res_n[p*BYTE_W +: BYTE_W] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)      res_q <= '0;
    else if (res_en) res_q <= res_n;
  end
endmodule

// File: rtl/rwc_compare.sv
module rwc_compare
  import rwc_pkg::*;
#(
  parameter int CMP_W = 32,
  localparam int NBYTE = CMP_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_l,
  input  logic [NBYTE-1:0]  byte_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CMP_W-1:0]  window,
  input  logic              done,
  input  logic              preset,
  output logic [CMP_W-1:0]  cmp_q,
  output logic              match_q
);
  logic [CMP_W-1:0] cmp_n;
  logic             match_n;
  logic             match_en;

  always_comb begin
    cmp_n = cmp_q;
    for (int k = 0; k < NBYTE; k++) begin
      if (byte_we[k]) cmp_n[k*BYTE_W +: BYTE_W] = wdata;
    end
  end

  always_comb begin
    match_en = preset | done;
    match_n  = preset ? 1'b0 : (window == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      cmp_q   <= '0;
      match_q <= 1'b0;
    end else begin
      if (|byte_we) cmp_q   <= cmp_n;
      if (match_en) match_q <= match_n;
    end
  end
endmodule

// File: rtl/residue_window_cmp.sv
module residue_window_cmp
  import rwc_pkg::*;
#(
  parameter int RES_W  = 40,
  parameter int CMP_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              upd_valid,
  input  logic [RES_W-1:0]  upd_value,
  input  logic              op_done,
  output logic [RES_W-1:0]  residue_out,
  output logic              match_flag
);
  localparam int NRES      = RES_W / BYTE_W;
  localparam int NCMP      = CMP_W / BYTE_W;
  localparam int CMP_BASE  = NRES;
  localparam int CTRL_ADDR = NRES + NCMP;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sr;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= 2'b00;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign rst_l = rst_sr[1];

  // control register
  logic ctrl_hit;
  logic order_q, order_n;
  logic preset_q, preset_n;

  always_comb begin
    ctrl_hit = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
    order_n  = ctrl_hit ? reg_wdata[ORDER_BIT] : order_q;
    preset_n = ctrl_hit && reg_wdata[PRESET_BIT];
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      order_q  <= 1'b0;
      preset_q <= 1'b0;
    end else begin
      if (ctrl_hit) order_q <= order_n;
      preset_q <= preset_n;
    end
  end

  // write decode
  logic [NRES-1:0] res_we;
  logic [NCMP-1:0] cmp_we;

  for (genvar p = 0; p < NRES; p++) begin : g_res_we
    localparam int MIRROR = NRES - 1 - p;
    assign res_we[p] = reg_wr &&
      (reg_addr == (order_q ? ADDR_W'(MIRROR) : ADDR_W'(p)));
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp_we
    assign cmp_we[k] = reg_wr && (reg_addr == ADDR_W'(CMP_BASE + k));
  end

  // datapath
  logic [RES_W-1:0] res_q;
  logic [CMP_W-1:0] cmp_q;
  logic [CMP_W-1:0] window;
  logic             match_q;

  rwc_residue #(.RES_W(RES_W)) u_residue (
    .clk       (clk),
    .rst_l     (rst_l),
    .preset    (preset_q),
    .upd_valid (upd_valid),
    .upd_value (upd_value),
    .byte_we   (res_we),
    .wdata     (reg_wdata),
    .res_q     (res_q)
  );

  assign window = order_q ? res_q[CMP_W-1:0] : res_q[RES_W-1 -: CMP_W];

  rwc_compare #(.CMP_W(CMP_W)) u_compare (
    .clk     (clk),
    .rst_l   (rst_l),
    .byte_we (cmp_we),
    .wdata   (reg_wdata),
    .window  (window),
    .done    (op_done),
    .preset  (preset_q),
    .cmp_q   (cmp_q),
    .match_q (match_q)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NRES; i++) begin
      if (reg_addr == ADDR_W'(i))
        reg_rdata = order_q ? res_q[(NRES-1-i)*BYTE_W +: BYTE_W]
                            : res_q[i*BYTE_W +: BYTE_W];
    end
    for (int k = 0; k < NCMP; k++) begin
      if (reg_addr == ADDR_W'(CMP_BASE + k))
        reg_rdata = cmp_q[k*BYTE_W +: BYTE_W];
    end
    if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
      reg_rdata[ORDER_BIT]  = order_q;
      reg_rdata[PRESET_BIT] = preset_q;
      reg_rdata[MATCH_BIT]  = match_q;
    end
  end

  assign residue_out = res_q;
  assign match_flag  = match_q;
endmodule

// File: rtl/rwc_checker.sv
module rwc_checker #(
  parameter int RES_W = 40,
  parameter int CMP_W = 32
) (
  input logic             clk,
  input logic             rst_l,
  input logic             preset_q,
  input logic             order_q,
  input logic             upd_valid,
  input logic [RES_W-1:0] upd_value,
  input logic             op_done,
  input logic [RES_W-1:0] residue_out,
  input logic [CMP_W-1:0] cmp_q,
  input logic             match_flag
);
  AST_PRESET_ONES: assert property (@(posedge clk) disable iff (!rst_l)
    preset_q |=> (residue_out == {RES_W{1'b1}})); // R3
  AST_PRESET_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_l)
    preset_q |=> !preset_q); // R3
  AST_PRESET_CLEARS_MATCH: assert property (@(posedge clk) disable iff (!rst_l)
    preset_q |=> !match_flag); // R4
  AST_UPDATE_LOADS: assert property (@(posedge clk) disable iff (!rst_l)
    (upd_valid && !preset_q) |=> (residue_out == $past(upd_value))); // R5
  AST_WINDOW_UPPER: assert property (@(posedge clk) disable iff (!rst_l)
    (op_done && !preset_q && !order_q) |=>
      (match_flag == ($past(residue_out[RES_W-1 -: CMP_W]) == $past(cmp_q)))); // R7
  AST_WINDOW_LOWER: assert property (@(posedge clk) disable iff (!rst_l)
    (op_done && !preset_q && order_q) |=>
      (match_flag == ($past(residue_out[CMP_W-1:0]) == $past(cmp_q)))); // R8
  AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_l)
    (!op_done && !preset_q) |=> $stable(match_flag)); // R9
endmodule

bind residue_window_cmp rwc_checker #(.RES_W(RES_W), .CMP_W(CMP_W)) u_rwc_checker (
  .clk         (clk),
  .rst_l       (rst_l),
  .preset_q    (preset_q),
  .order_q     (order_q),
  .upd_valid   (upd_valid),
  .upd_value   (upd_value),
  .op_done     (op_done),
  .residue_out (residue_out),
  .cmp_q       (cmp_q),
  .match_flag  (match_flag)
);

// File: tb/residue_window_cmp_bench.sv
`timescale 1ns/1ps
module residue_window_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        upd_valid = 1'b0;
  logic [39:0] upd_value = '0;
  logic        op_done = 1'b0;
  logic [39:0] residue_out;
  logic        match_flag;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  residue_window_cmp u_residue_window_cmp (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_valid(upd_valid),
    .upd_value(upd_value), .op_done(op_done), .residue_out(residue_out),
    .match_flag(match_flag)
  );

  // {order, residue, compare, expected match}
  localparam logic [73:0] VEC [7] = '{
    {1'b0, 40'hDEADBEEF5A, 32'hDEADBEEF, 1'b1},
    {1'b1, 40'h5ADEADBEEF, 32'hDEADBEEF, 1'b1},
    {1'b0, 40'h5ADEADBEEF, 32'hDEADBEEF, 1'b0},
    {1'b1, 40'hDEADBEEF5A, 32'hDEADBEEF, 1'b0},
    {1'b1, 40'hFF00000000, 32'h00000000, 1'b1},
    {1'b0, 40'h00000000FF, 32'h00000000, 1'b1},
    {1'b0, 40'h8000000000, 32'h00000000, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  function automatic logic [7:0] res_byte(input logic ord, input logic [39:0] r, input int i);
    return ord ? r[(4-i)*8 +: 8] : r[i*8 +: 8];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  rd;
    logic [39:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 residue", residue_out, 0);
    check("R1 match", match_flag, 0);
    bus_read(4'd9, rd); check("R1 ctrl", rd, 0);
    bus_read(4'd5, rd); check("R1 cmp", rd, 0);

    // table walk: R2, R7, R8
    foreach (VEC[v]) begin
      logic        ord;
      logic [39:0] r;
      logic [31:0] c;
      logic        m;
      {ord, r, c, m} = VEC[v];
      bus_write(4'd9, {7'd0, ord});
      for (int i = 0; i < 5; i++) bus_write(4'(i), res_byte(ord, r, i));
      for (int k = 0; k < 4; k++) bus_write(4'(5 + k), c[k*8 +: 8]);
      pulse_done();
      check("R2 residue write mapping", residue_out, r);
      check(ord ? "R8 lower window match" : "R7 upper window match", match_flag, m);
      bus_read(4'd9, rd);
      check("R9 ctrl match bit", rd[2], m);
      for (int i = 0; i < 5; i++) begin
        bus_read(4'(i), rd);
        check("R2 residue read mapping", rd, res_byte(ord, r, i));
      end
    end

    // R6 compare readback
    for (int k = 0; k < 4; k++) bus_write(4'(5 + k), 8'(8'h11 * (k + 1)));
    for (int k = 0; k < 4; k++) begin
      bus_read(4'(5 + k), rd);
      check("R6 compare byte", rd, 8'h11 * (k + 1));
    end

    // R9 hold: residue upper = 44332211, order 0
    bus_write(4'd9, 8'h00);
    bus_write(4'd4, 8'h44); bus_write(4'd3, 8'h33);
    bus_write(4'd2, 8'h22); bus_write(4'd1, 8'h11);
    pulse_done();
    check("R7 match set", match_flag, 1);
    bus_write(4'd4, 8'h00);
    check("R9 match holds without done", match_flag, 1);
    bus_write(4'd9, 8'h00);
    bus_read(4'd9, rd);
    check("R9 ctrl bit2 write ignored", rd, 8'h04);

    // R3/R4 preset with same-cycle update
    bus_write(4'd9, 8'h02);
    upd_valid = 1'b1; upd_value = 40'h0123456789;
    bus_read(4'd9, rd);
    check("R3 preset bit pending", rd, 8'h06);
    @(negedge clk);
    upd_valid = 1'b0;
    check("R4 preset beats update", residue_out, 40'hFFFFFFFFFF);
    check("R4 preset clears match", match_flag, 0);
    bus_read(4'd9, rd);
    check("R3 preset self clear", rd, 8'h00);

    // R5 update beats bus write
    @(negedge clk);
    upd_valid = 1'b1; upd_value = 40'h0102030405;
    reg_addr = 4'd0; reg_wdata = 8'hAA; reg_wr = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0; reg_wr = 1'b0;
    check("R5 update loads residue", residue_out, 40'h0102030405);
    bus_write(4'd9, 8'h01);
    bus_read(4'd0, rd);
    check("R2 reversed order byte 0", rd, 8'h01);

    // R10 unmapped
    snap = residue_out;
    bus_write(4'd12, 8'hFF);
    bus_write(4'd15, 8'hFF);
    check("R10 write ignored residue", residue_out, snap);
    bus_read(4'd9, rd);  check("R10 write ignored ctrl", rd, 8'h01);
    bus_read(4'd12, rd); check("R10 unmapped read", rd, 0);
    bus_read(4'd15, rd); check("R10 unmapped read top", rd, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule